// File: doc/BRIEF.md
# Carry-Aware Integer Add and Reverse-Subtract Unit

This block is the add/subtract slice of an integer execution stage. It takes two operands, A and B, and a small operation code. It returns a result that is either A plus B or B minus A. The second operand can come from a register or from an already-extended immediate; the block makes no distinction between the two. Two further operations compare A with B, one signed and one unsigned. Each produces B minus A with its top bit rewritten so that the bit gives the ordering.

The arithmetic path is purely combinational. A single carry flag register lives inside the unit. Each cycle the unit presents the flag's candidate next value and a write enable, and the flag loads that value on the rising clock edge when the enable is high. Depending on the operation code, the stored flag is used as the carry-in of the addition, and its update is either performed or suppressed. Instruction decode, register access and immediate extension stay outside the block.

Top module: `acu_top`

## Requirements
- R1: With `cmp_i` low and `op_i[0]` = 0, `result_o` is A + B + cin modulo 2^W. cin is 0 unless `op_i[1]` is set.
- R2: With `cmp_i` low and `op_i[0]` = 1, `result_o` is B + ~A + cin modulo 2^W. cin is 1 unless `op_i[1]` is set, so the plain form gives B minus A.
- R3: When `op_i[1]` = 1 (and `cmp_i` low), cin is the value held in the carry flag, for both add and reverse subtract.
- R4: With `cmp_i` low, `carry_next_o` is the carry out of bit W-1 of the W-bit addition of R1 or R2. `carry_we_o` is 1 whenever `op_i[2]` = 0.
- R5: When `op_i[2]` = 1 (keep mode), the result is the same as for the matching code with bit 2 clear. `carry_we_o` is 0, and the stored flag is unchanged after the clock edge.
- R6: With `cmp_i` = 1 and `cmp_unsigned_i` = 0, `result_o` is B + ~A + 1. When bit W-1 of A and B differ, bit W-1 of the result is replaced by bit W-1 of B.
- R7: With `cmp_i` = 1 and `cmp_unsigned_i` = 1, `result_o` is the same difference. When bit W-1 of A and B differ, bit W-1 of the result is replaced by bit W-1 of A.
- R8: With `cmp_i` = 1, `op_i` has no effect, `carry_we_o` is 0, and the stored flag is unchanged after the clock edge.
- R9: The carry flag is 0 after reset. On a rising clock edge with `carry_we_o` = 1 it takes the value of `carry_next_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the carry flag |
| rst_ni | input | 1 | Active-low asynchronous reset of the carry flag |
| op_i | input | 3 | Bit 0 reverse subtract, bit 1 carry-in from flag, bit 2 keep flag |
| cmp_i | input | 1 | Selects a compare instead of add/subtract |
| cmp_unsigned_i | input | 1 | Compare flavour: 1 unsigned, 0 signed |
| a_i | input | W | Operand A |
| b_i | input | W | Operand B (register or extended immediate) |
| result_o | output | W | Arithmetic or compare result |
| carry_next_o | output | 1 | Candidate next value of the carry flag |
| carry_we_o | output | 1 | Write enable for the carry flag |

## Verification
The bench uses an 8-bit instance with the ripple adder variant. It sweeps a grid of operand pairs that includes zero, all ones, the values just below and at the sign boundary, and evenly spaced mixed patterns. Every one of the eight operation codes and both compares is applied to each pair. Pairs with equal and with unequal top bits separate the two compare fix-ups from each other and from a plain subtraction. Pairs near wrap-around separate a correct carry-out from a dropped or inverted one. Because the stored flag drifts between 0 and 1 during the sweep, each carry-in code is tried with both flag values. Directed sequences then load the flag, apply a keep or compare operation that would have cleared it, and read the flag back through a carry-in addition of zero and zero.

// File: rtl/acu_pkg.sv
package acu_pkg;
   // operation code bit positions
   localparam int unsigned OP_W       = 3;
   localparam int unsigned OP_REV_BIT = 0;
   localparam int unsigned OP_CIN_BIT = 1;
   localparam int unsigned OP_KEEP_BIT = 2;

   typedef enum logic {
      ADDER_NATIVE = 1'b0,
      ADDER_RIPPLE = 1'b1
   } adder_style_e;
endpackage

// File: rtl/acu_operand_prep.sv
module acu_operand_prep
   import acu_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [OP_W-1:0] op_i,
   input  logic            cmp_i,
   input  logic            flag_i,
   input  logic [W-1:0]    a_i,
   input  logic [W-1:0]    b_i,
   output logic [W-1:0]    x_o,
   output logic [W-1:0]    y_o,
   output logic            cin_o
);
   logic rev;

   // compare always runs as a reverse subtract with forced carry-in
   assign rev = cmp_i | op_i[OP_REV_BIT];

   always_comb begin
      if (rev) begin
         x_o = b_i;
         y_o = ~a_i;
      end else begin
         x_o = a_i;
         y_o = b_i;
      end
      if (cmp_i)
         cin_o = 1'b1;
      else if (op_i[OP_CIN_BIT])
         cin_o = flag_i;
      else
         cin_o = op_i[OP_REV_BIT];
   end
endmodule

// File: rtl/acu_adder.sv
module acu_adder
   import acu_pkg::*;
#(
   parameter int unsigned  W     = 32,
   parameter adder_style_e STYLE = ADDER_NATIVE
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);
   generate
      if (STYLE == ADDER_RIPPLE) begin : g_ripple
         logic [W:0] c;
         assign c[0] = cin_i;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum_o[i] = x_i[i] ^ y_i[i] ^ c[i];
            assign c[i+1]   = (x_i[i] & y_i[i]) | (c[i] & (x_i[i] ^ y_i[i]));
         end
         assign cout_o = c[W];
      end else begin : g_native
         logic [W:0] wide;
         assign wide   = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
         assign sum_o  = wide[W-1:0];
         assign cout_o = wide[W];
      end
   endgenerate
endmodule

// File: rtl/acu_cmp_fix.sv
module acu_cmp_fix #(
   parameter int unsigned W = 32
) (
   input  logic         cmp_i,
   input  logic         cmp_unsigned_i,
   input  logic         a_msb_i,
   input  logic         b_msb_i,
   input  logic [W-1:0] sum_i,
   output logic [W-1:0] result_o
);
   localparam int unsigned MSB = W - 1;
   logic mismatch;

   assign mismatch = a_msb_i ^ b_msb_i;

   always_comb begin
      result_o = sum_i;
      if (cmp_i && mismatch)
         result_o[MSB] = cmp_unsigned_i ? a_msb_i : b_msb_i;
   end
endmodule

// File: rtl/acu_carry_flag.sv
module acu_carry_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic we_i,
   input  logic d_i,
   output logic q_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         q_o <= 1'b0;
      else if (we_i)
         q_o <= d_i;
   end

   // R9
   flag_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |=> (q_o == $past(d_i)));
   // R5
   flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> $stable(q_o));
endmodule

// File: rtl/acu_top.sv
module acu_top
   import acu_pkg::*;
#(
   parameter int unsigned  W     = 32,
   parameter adder_style_e STYLE = ADDER_NATIVE
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [2:0]      op_i,
   input  logic            cmp_i,
   input  logic            cmp_unsigned_i,
   input  logic [W-1:0]    a_i,
   input  logic [W-1:0]    b_i,
   output logic [W-1:0]    result_o,
   output logic            carry_next_o,
   output logic            carry_we_o
);
   localparam int unsigned MSB = W - 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("acu_top: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] x, y, sum;
   logic         cin, cout, flag_q;

   acu_operand_prep #(.W(W)) u_prep (
      .op_i   (op_i),
      .cmp_i  (cmp_i),
      .flag_i (flag_q),
      .a_i    (a_i),
      .b_i    (b_i),
      .x_o    (x),
      .y_o    (y),
      .cin_o  (cin)
   );

   acu_adder #(.W(W), .STYLE(STYLE)) u_add (
      .x_i    (x),
      .y_i    (y),
      .cin_i  (cin),
      .sum_o  (sum),
      .cout_o (cout)
   );

   acu_cmp_fix #(.W(W)) u_fix (
      .cmp_i          (cmp_i),
      .cmp_unsigned_i (cmp_unsigned_i),
      .a_msb_i        (a_i[MSB]),
      .b_msb_i        (b_i[MSB]),
      .sum_i          (sum),
      .result_o       (result_o)
   );

   assign carry_next_o = cout;
   assign carry_we_o   = ~cmp_i & ~op_i[OP_KEEP_BIT];

   acu_carry_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (carry_we_o),
      .d_i    (carry_next_o),
      .q_o    (flag_q)
   );

   // R1 R4
   plain_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cmp_i && op_i[1:0] == 2'b00)
         |-> ({carry_next_o, result_o} == ({1'b0, a_i} + {1'b0, b_i})));
   // R2
   plain_rsub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cmp_i && op_i[1:0] == 2'b01) |-> (result_o == b_i - a_i));
   // R6 R7
   cmp_same_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_i && (a_i[MSB] == b_i[MSB])) |-> (result_o == b_i - a_i));
   // R7
   cmpu_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_i && cmp_unsigned_i && (a_i[MSB] != b_i[MSB])) |-> (result_o[MSB] == a_i[MSB]));
   // R6
   cmps_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_i && !cmp_unsigned_i && (a_i[MSB] != b_i[MSB])) |-> (result_o[MSB] == b_i[MSB]));
   // R8
   cmp_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_i |=> $stable(flag_q));
endmodule

// File: tb/acu_top_tb.sv
`timescale 1ns/1ps
module acu_top_tb;
   import acu_pkg::*;
   localparam int unsigned W = 8;
   localparam int unsigned NV = 19;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   op = '0;
   logic         cmp = 1'b0;
   logic         cmpu = 1'b0;
   logic [W-1:0] a = '0;
   logic [W-1:0] b = '0;
   logic [W-1:0] res;
   logic         cnext, cwe;

   int checks = 0;
   int fails  = 0;
   logic exp_c = 1'b0;
   logic [W-1:0] e_res;
   logic e_cn, e_we;

   always #2.5 clk = ~clk;

   acu_top #(.W(W), .STYLE(ADDER_RIPPLE)) u_dut (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .op_i           (op),
      .cmp_i          (cmp),
      .cmp_unsigned_i (cmpu),
      .a_i            (a),
      .b_i            (b),
      .result_o       (res),
      .carry_next_o   (cnext),
      .carry_we_o     (cwe)
   );

   function automatic logic [W-1:0] pick(int k);
      if (k < 16) return W'(k * 17);
      else if (k == 16) return 8'h7F;
      else if (k == 17) return 8'h80;
      else return 8'h01;
   endfunction

   task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: op=%0d cmp=%0d u=%0d a=%h b=%h actual=%h expected=%h",
                  tag, op, cmp, cmpu, a, b, act, exp);
      end
   endtask

   // expected values from the requirements
   task automatic model();
      logic [W:0] s;
      logic cin;
      if (cmp) begin
         s = {1'b0, b} + {1'b0, ~a} + 1;
         e_res = s[W-1:0];
         if (a[W-1] != b[W-1]) e_res[W-1] = cmpu ? a[W-1] : b[W-1];
         e_cn = s[W];
         e_we = 1'b0;
      end else begin
         cin = op[1] ? exp_c : op[0];
         if (op[0]) s = {1'b0, b} + {1'b0, ~a} + {{W{1'b0}}, cin};
         else       s = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
         e_res = s[W-1:0];
         e_cn = s[W];
         e_we = ~op[2];
      end
   endtask

   // one operation in one cycle; the flag model follows the edge
   task automatic step(logic [2:0] o, logic c, logic u, logic [W-1:0] av, logic [W-1:0] bv);
      @(negedge clk);
      op = o; cmp = c; cmpu = u; a = av; b = bv;
      #1;
      model();
      if (c) begin
         chk(u ? "R7 unsigned compare" : "R6 signed compare", res, e_res);
         chk("R8 compare write enable", {7'd0, cwe}, 8'd0);
      end else begin
         chk(o[0] ? "R2 reverse subtract result" : "R1 add result", res, e_res);
         chk("R4 carry out", {7'd0, cnext}, {7'd0, e_cn});
         chk(o[2] ? "R5 keep write enable" : "R4 write enable", {7'd0, cwe}, {7'd0, e_we});
      end
      @(posedge clk);
      if (e_we) exp_c = e_cn;
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R9: flag starts at 0; read it back with a keep carry-in add of zeros
      @(negedge clk);
      op = 3'b110; cmp = 1'b0; a = '0; b = '0;
      #1;
      chk("R9 flag after reset", res, 8'h00);
      // R3: flag of 1 read back through both carry-in flavours
      step(3'b000, 1'b0, 1'b0, 8'hFF, 8'h01);
      @(negedge clk); op = 3'b110; a = '0; b = '0; #1;
      chk("R3 R9 flag loaded to 1", res, 8'h01);
      // R5: keep add that would clear the flag must leave it at 1
      step(3'b100, 1'b0, 1'b0, 8'h00, 8'h00);
      @(negedge clk); op = 3'b110; a = '0; b = '0; #1;
      chk("R5 flag kept", res, 8'h01);
      // R8: compare with garbage op code must leave the flag at 1
      step(3'b001, 1'b1, 1'b0, 8'h05, 8'h03);
      step(3'b011, 1'b1, 1'b1, 8'h00, 8'h00);
      @(negedge clk); op = 3'b110; cmp = 1'b0; a = '0; b = '0; #1;
      chk("R8 flag after compare", res, 8'h01);
      // R3: reverse subtract with flag-driven carry-in, flag 1 gives B-A
      @(negedge clk); op = 3'b111; a = 8'h03; b = 8'h0A; #1;
      chk("R3 reverse with stored carry", res, 8'h07);
      // sweep of all codes and both compares over the operand grid
      for (int i = 0; i < NV; i++) begin
         for (int j = 0; j < NV; j++) begin
            for (int o = 0; o < 8; o++)
               step(3'(o), 1'b0, 1'b0, pick(i), pick(j));
            step(3'(i % 8), 1'b1, 1'b0, pick(i), pick(j));
            step(3'(j % 8), 1'b1, 1'b1, pick(i), pick(j));
         end
      end
      // R9: flag cleared by a write of 0
      step(3'b000, 1'b0, 1'b0, 8'h00, 8'h00);
      @(negedge clk); op = 3'b110; a = '0; b = '0; #1;
      chk("R9 flag cleared", res, 8'h00);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule